// File: doc/BRIEF.md
# I2C Misplaced Start/Stop Abort Unit

This unit sits next to an I2C controller and watches the synchronized SCL and SDA lines, together with two facts supplied by the controller: whether it is currently taking part in a transfer, either as the active master or as an addressed slave, and which part of the frame is in progress. The frame part is one of idle, address bit, data bit or acknowledge bit. A Start condition is SDA falling while SCL stays high. A Stop condition is SDA rising while SCL stays high. A Start or Stop that turns up while a frame part is in progress is illegal, and the unit treats it as a bus error.

On a bus error the unit aborts the controller in a single registered step. It lets go of both bus lines, sends a one-cycle pulse that forces the controller into not-addressed slave mode, writes the error status code 0x00 into the status register, and raises the interrupt flag. The error stays latched, with both lines released, until software clears the interrupt flag. A misplaced condition is ignored when the controller is not involved in a transfer, and when the frame part is idle.

The unit also keeps a bit-position counter for the frame in progress. It counts SCL rising edges from 0 to 8, covering eight data bits and one acknowledge bit, and then wraps.

Top module: `i2c_bus_err_det`

## Requirements
- R1: When `involved`=1, `phase` is not idle, and a Start (SDA 1→0 while SCL stays 1) is sampled, `irq` rises at the same clock edge that samples the new SDA value.
- R2: The same holds for a Stop (SDA 0→1 while SCL stays 1).
- R3: A Start or Stop sampled while `involved`=0 leaves `irq`, `force_nas`, `stat_wr`, both release outputs and `stat_data` (0xF8) unchanged.
- R4: A Start or Stop sampled while `phase`=2'b00 (idle) has no effect on any of those outputs. The phase codes are 2'b01 address, 2'b10 data and 2'b11 acknowledge.
- R5: Once an error is taken, `sda_rel` and `scl_rel` are both 1 and stay 1 until the error is cleared.
- R6: `force_nas` is a pulse exactly one cycle long, issued in the cycle in which the error is taken.
- R7: When an error is taken, `stat_wr` pulses for one cycle and `stat_data` becomes 0x00. Without a pending error, `stat_data` reads 0xF8.
- R8: With `irq_clr`=1 at a clock edge, that edge clears `irq`, both release outputs and the pending error, and `stat_data` returns to 0xF8.
- R9: `bit_pos` counts SCL rising edges while `phase` is not idle, going 0,1,…,8 and then back to 0. It is forced to 0 by a Start, by a Stop, or by the idle phase, and it never exceeds 8.
- R10: SDA changes while SCL is low are not conditions and raise no error.
- R11: After reset, `irq`, both release outputs, `force_nas`, `stat_wr` and `bit_pos` are 0, and `stat_data` is 0xF8.
- R12: A further misplaced condition while an error is pending produces no new `force_nas` or `stat_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_s | input | 1 | Synchronized SCL level |
| sda_s | input | 1 | Synchronized SDA level |
| involved | input | 1 | Controller is active master or addressed slave |
| phase | input | 2 | Frame part: 00 idle, 01 address, 10 data, 11 acknowledge |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| sda_rel | output | 1 | Release SDA (error pending) |
| scl_rel | output | 1 | Release SCL (error pending) |
| force_nas | output | 1 | One-cycle pulse that forces not-addressed slave mode |
| stat_wr | output | 1 | One-cycle status-register write strobe |
| stat_data | output | 8 | Status value: 0x00 after an error, otherwise 0xF8 |
| irq | output | 1 | Interrupt flag |
| bit_pos | output | 4 | Bit position in the frame, 0 to 8 |

## Verification
A stale copy of SCL or SDA in the edge detector makes a misplaced condition appear, or vanish, at the very next clock edge. Because all reactions are registered, that shows on `irq`, on the release outputs and on `stat_data` one cycle after the lines change. A pending-error flag that is stuck high suppresses the `force_nas` and `stat_wr` pulses of the next error. A pending-error flag that is stuck low keeps the release outputs low right after the error, or repeats the pulses on a second condition. A bit counter with a wrong wrap point is visible on `bit_pos` at the ninth SCL rising edge of a frame.

// File: rtl/i2c_bed_pkg.sv
package i2c_bed_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_ACK  = 2'b11
  } phase_e;

  localparam int unsigned STAT_W      = 8;
  localparam logic [7:0]  STAT_BUSERR = 8'h00;
  localparam logic [7:0]  STAT_NOINFO = 8'hF8;

endpackage

// File: rtl/i2c_bed_cond.sv
module i2c_bed_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_c,
  output logic stop_c,
  output logic scl_rise
);

  logic scl_q;
  logic sda_q;

  // the previous level resets to the idle-bus value, so reset makes no edge
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    start_c  = scl_q & scl_s & sda_q & ~sda_s;
    stop_c   = scl_q & scl_s & ~sda_q & sda_s;
    scl_rise = ~scl_q & scl_s;
  end

endmodule

// File: rtl/i2c_bed_bitcnt.sv
module i2c_bed_bitcnt #(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             frame_on,
  input  logic             restart,
  output logic [CNT_W-1:0] pos
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst || !frame_on || restart) begin
      pos <= '0;
    end else if (scl_rise) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_bed_errctl.sv
module i2c_bed_errctl #(
  parameter int unsigned SW = 8,
  parameter logic [SW-1:0] ERR_CODE  = '0,
  parameter logic [SW-1:0] IDLE_CODE = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          involved,
  input  logic          frame_on,
  input  logic          irq_clr,
  output logic          err_hold,
  output logic          force_nas,
  output logic          stat_wr,
  output logic [SW-1:0] stat_data,
  output logic          irq
);

  logic hit;

  always_comb begin
    hit = (start_c | stop_c) & involved & frame_on & ~err_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_hold  <= 1'b0;
      force_nas <= 1'b0;
      stat_wr   <= 1'b0;
      stat_data <= IDLE_CODE;
      irq       <= 1'b0;
    end else begin
      force_nas <= hit;
      stat_wr   <= hit;
      if (hit) begin
        err_hold  <= 1'b1;
        irq       <= 1'b1;
        stat_data <= ERR_CODE;
      end else if (irq_clr) begin
        err_hold  <= 1'b0;
        irq       <= 1'b0;
        stat_data <= IDLE_CODE;
      end
    end
  end

endmodule

// File: rtl/i2c_bus_err_det.sv
module i2c_bus_err_det
  import i2c_bed_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              involved,
  input  logic [1:0]        phase,
  input  logic              irq_clr,
  output logic              sda_rel,
  output logic              scl_rel,
  output logic              force_nas,
  output logic              stat_wr,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq,
  output logic [CNT_W-1:0]  bit_pos
);

  logic start_c;
  logic stop_c;
  logic scl_rise;
  logic frame_on;
  logic err_hold;

  always_comb begin
    frame_on = (phase_e'(phase) != PH_IDLE);
  end

  i2c_bed_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .scl_rise (scl_rise)
  );

  i2c_bed_bitcnt #(.FRAME_BITS(FRAME_BITS)) u_bitcnt (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .frame_on (frame_on),
    .restart  (start_c | stop_c),
    .pos      (bit_pos)
  );

  i2c_bed_errctl #(
    .SW        (STAT_W),
    .ERR_CODE  (STAT_BUSERR),
    .IDLE_CODE (STAT_NOINFO)
  ) u_errctl (
    .clk       (clk),
    .rst       (rst),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .involved  (involved),
    .frame_on  (frame_on),
    .irq_clr   (irq_clr),
    .err_hold  (err_hold),
    .force_nas (force_nas),
    .stat_wr   (stat_wr),
    .stat_data (stat_data),
    .irq       (irq)
  );

  always_comb begin
    sda_rel = err_hold;
    scl_rel = err_hold;
  end

endmodule

// File: rtl/i2c_bed_chk.sv
module i2c_bed_chk #(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_c,
  input logic             stop_c,
  input logic             involved,
  input logic [1:0]       phase,
  input logic             irq_clr,
  input logic             sda_rel,
  input logic             scl_rel,
  input logic             force_nas,
  input logic             stat_wr,
  input logic [7:0]       stat_data,
  input logic             irq,
  input logic [CNT_W-1:0] bit_pos
);

  // R1
  take_err_chk: assert property (@(posedge clk) disable iff (rst)
    ((start_c || stop_c) && involved && phase != 2'b00 && !irq) |=> irq);

  // R3
  not_involved_chk: assert property (@(posedge clk) disable iff (rst)
    (!involved && !irq) |=> !irq);

  // R4
  idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && !irq) |=> !irq);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sda_rel && scl_rel));

  // R6
  nas_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    force_nas |=> !force_nas);

  // R7
  stat_code_chk: assert property (@(posedge clk) disable iff (rst)
    stat_wr |-> (stat_data == 8'h00 && irq));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && irq) |=> (!irq && !sda_rel && !scl_rel));

  // R9
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_pos < CNT_W'(FRAME_BITS));

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(irq)) |-> !stat_wr);

endmodule

bind i2c_bus_err_det i2c_bed_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_c   (start_c),
  .stop_c    (stop_c),
  .involved  (involved),
  .phase     (phase),
  .irq_clr   (irq_clr),
  .sda_rel   (sda_rel),
  .scl_rel   (scl_rel),
  .force_nas (force_nas),
  .stat_wr   (stat_wr),
  .stat_data (stat_data),
  .irq       (irq),
  .bit_pos   (bit_pos)
);

// File: tb/test_i2c_bus_err_det.sv
module test_i2c_bus_err_det;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_s = 1'b1;
  logic       sda_s = 1'b1;
  logic       involved = 1'b0;
  logic [1:0] phase = 2'b00;
  logic       irq_clr = 1'b0;
  logic       sda_rel, scl_rel, force_nas, stat_wr, irq;
  logic [7:0] stat_data;
  logic [3:0] bit_pos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  i2c_bus_err_det i_i2c_bus_err_det (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .involved(involved), .phase(phase), .irq_clr(irq_clr),
    .sda_rel(sda_rel), .scl_rel(scl_rel), .force_nas(force_nas),
    .stat_wr(stat_wr), .stat_data(stat_data), .irq(irq), .bit_pos(bit_pos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    scl_s = c;
    sda_s = d;
    @(negedge clk);
  endtask

  task automatic go_high();
    step(1'b0, sda_s);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
  endtask

  task automatic do_start();
    go_high();
    step(1'b1, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b0, sda_s);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic clear_err();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", irq, 0);
    chk("R11 release", sda_rel | scl_rel, 0);
    chk("R11 force_nas", force_nas, 0);
    chk("R11 stat_wr", stat_wr, 0);
    chk("R11 stat_data", stat_data, 8'hF8);
    chk("R11 bit_pos", bit_pos, 0);

    // sweep: involvement x phase x condition kind (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int inv = 0; inv < 2; inv++) begin
      for (int ph = 0; ph < 4; ph++) begin
        for (int k = 0; k < 2; k++) begin
          string tag;
          int exp;
          involved = inv[0];
          phase = ph[1:0];
          if (k == 0) do_start(); else do_stop();
          exp = (inv == 1 && ph != 0) ? 1 : 0;
          tag = (inv == 0) ? "R3" : (ph == 0) ? "R4" : (k == 0) ? "R1" : "R2";
          chk(tag, irq, exp);
          chk("R5 release", {30'd0, sda_rel, scl_rel}, exp * 3);
          chk("R6 force_nas", force_nas, exp);
          chk("R7 stat_wr", stat_wr, exp);
          chk("R7 stat_data", stat_data, exp ? 8'h00 : 8'hF8);
          @(negedge clk);
          chk("R6 pulse end", force_nas, 0);
          chk("R5 held", sda_rel & scl_rel, exp);
          clear_err();
          chk("R8 irq", irq, 0);
          chk("R8 release", sda_rel | scl_rel, 0);
          chk("R8 stat_data", stat_data, 8'hF8);
        end
      end
    end

    // R12 second condition while pending
    involved = 1'b1;
    phase = 2'b01;
    do_start();
    chk("R12 first", stat_wr, 1);
    do_start();
    chk("R12 no nas", force_nas, 0);
    chk("R12 no wr", stat_wr, 0);
    chk("R12 irq", irq, 1);
    do_stop();
    chk("R12 stop no wr", stat_wr, 0);
    clear_err();

    // R10 SDA activity while SCL low
    phase = 2'b10;
    step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0]);
      chk("R10", irq | force_nas, 0);
    end
    step(1'b0, 1'b1);

    // R9 bit counting
    involved = 1'b0;
    phase = 2'b00;
    @(negedge clk);
    phase = 2'b10;
    for (int i = 1; i <= 20; i++) begin
      step(1'b1, 1'b1);
      chk("R9 count", bit_pos, i % FRAME_BITS);
      step(1'b0, 1'b1);
    end
    step(1'b1, 1'b1);
    chk("R9 count", bit_pos, 21 % FRAME_BITS);
    step(1'b1, 1'b0);
    chk("R9 start reset", bit_pos, 0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R9 count", bit_pos, 1);
    phase = 2'b00;
    @(negedge clk);
    chk("R9 idle reset", bit_pos, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule